// File: doc/BRIEF.md
# Scan-Mode Conversion Sequencer

This block runs an external successive-approximation converter through a small group of adjacent analog channels, over and over, for as long as software keeps its run bit set. A write that sets the run bit takes the group (a first channel and a count of one to four) and starts a short, variable start delay. After that delay the sequencer opens a sampling window for the first channel, hands the converter a conversion request, and waits for the result. Each returned result lands in that channel's own result register. When the last channel of the group has been stored, a sticky completion flag is raised, and the sequencer moves straight on to the first channel of the group again. Only the first channel after a start pays the start delay.

A write that clears the run bit stops everything at once and returns the sequencer to idle. A later start always begins at the first channel of the group, with a fresh start delay. Software reads results through a select/data read port, clears the flag with a one-cycle pulse, and can see an interrupt line that follows the flag gated by an enable bit.

The converter request is a valid/ready stream. The sequencer holds `req_valid` with a stable `req_ch` until `req_ready` is seen, so the converter may back-pressure for any number of cycles. The one exception is a stop write, which withdraws a pending request. The result stream never back-pressures: `res_ready` is high in every cycle after reset. A result handed over while the sequencer is not waiting for one is accepted and dropped.

Top module: `adc_scan_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sh_en`, `req_valid`, `done_flag` and `irq` are 0, and every result register reads 0. `res_ready` is 0 during reset.
- R2: A free-running prescaler counts 0 to PRE_DIV-1, starting at 0 on the first clock after reset. A write with `cfg_we`=1 and `cfg_start`=1 while the run bit is 0 starts a delay of D = PRE_DIV minus the prescaler value at that edge, so D is in 1..PRE_DIV. `sh_en` rises D cycles after the start edge. Later channels of the same run have no delay.
- R3: `sh_en` stays high for exactly SAMP_CYC cycles per channel, with `sh_ch` naming that channel. Channels are visited in the order first, first+1, … for the group count, and the order then repeats at once while the run bit stays 1. `sh_en` and `req_valid` are never high together.
- R4: After the sampling window, `req_valid` rises with `req_ch` equal to the sampled channel. It stays high with `req_ch` unchanged until a cycle with `req_ready`=1, and the sequencer then waits for a result.
- R5: A result with `res_valid`=1 while the sequencer is waiting is written to the result register of the current channel. A result at any other time is accepted and dropped. `res_ready` is 1 in every cycle after reset.
- R6: `done_flag` is set when the result of the last channel of the group is stored. A `flag_clr` pulse clears it. If both happen in the same cycle, the flag ends up set.
- R7: `irq` is high exactly when `done_flag` is 1 and the interrupt enable (written from `cfg_irq_en` on every `cfg_we`) is 1.
- R8: `rd_data` shows, in the same cycle, the result register chosen by `rd_sel`.
- R9: A write with `cfg_we`=1 and `cfg_start`=0 sends the sequencer to idle at that edge. From the next cycle `sh_en` and `req_valid` are 0, and a result arriving in that same cycle is not stored. A later start begins at the group's first channel, after a new start delay.
- R10: A write with `cfg_start`=1 while already running does not change the group or the position in the sequence. A new group takes effect only through a stop and a restart.
- R11: The group is given as `cfg_first` (channel number 0..NUM_CH-1) and `cfg_cnt` (number of channels minus 1). Channel numbers wrap modulo NUM_CH, so first 6 with count field 3 visits 6, 7, 0, 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_start | input | 1 | Run bit value written |
| cfg_irq_en | input | 1 | Interrupt enable value written |
| cfg_first | input | 3 | First channel of the group (taken at start) |
| cfg_cnt | input | 2 | Channels in group minus 1 (taken at start) |
| flag_clr | input | 1 | Pulse that clears the completion flag |
| rd_sel | input | 3 | Result register select |
| rd_data | output | 10 | Selected result register |
| done_flag | output | 1 | Sticky pass-completion flag |
| irq | output | 1 | Interrupt request level |
| sh_en | output | 1 | Sampling window active |
| sh_ch | output | 3 | Channel being sampled |
| req_valid | output | 1 | Conversion request valid |
| req_ready | input | 1 | Converter accepts request |
| req_ch | output | 3 | Channel of the conversion request |
| res_valid | input | 1 | Converter result valid |
| res_ready | output | 1 | Result accepted (high after reset) |
| res_data | input | 10 | Converter result |

## Verification
Two collisions matter. Pass completion and a software flag clear can land on the same edge. The bench watches its reference model, pulses `flag_clr` in exactly the cycle in which the last channel's result is consumed (after first clearing the flag), and expects the flag to read 1 afterwards. A stop write can also coincide with a pending request or an arriving result. The bench holds `req_ready` low, issues the stop, and expects `req_valid` to drop and no result register to change, which the every-cycle comparison of `rd_data` against the model confirms.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DELAY,
    ST_SAMPLE,
    ST_REQ,
    ST_WAIT
  } seq_state_e;

endpackage

// File: rtl/adc_scan_delay.sv
// Free-running prescaler; the start delay length is derived from its phase.
module adc_scan_delay #(
  parameter int PRE_DIV = 4,
  parameter int CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] delay_len
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic [PW-1:0] pre_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt <= '0;
    end else if (pre_cnt == PW'(PRE_DIV - 1)) begin
      pre_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  // Range 1..PRE_DIV: a write early in the prescaler period waits longest.
  assign delay_len = CNT_W'(PRE_DIV) - CNT_W'(pre_cnt);

endmodule

// File: rtl/adc_scan_resbank.sv
// Per-channel result registers with one write port and one read port.
module adc_scan_resbank #(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  parameter int CH_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CH_W-1:0]  waddr,
  input  logic [RES_W-1:0] wdata,
  input  logic [CH_W-1:0]  raddr,
  output logic [RES_W-1:0] rdata
);
  logic [RES_W-1:0] bank [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank[g] <= '0;
      end else if (we && (waddr == CH_W'(g))) begin
        bank[g] <= wdata;
      end
    end
  end

  assign rdata = bank[raddr];

endmodule

// File: rtl/adc_scan_fsm.sv
// Channel sequencer: start delay, sampling window, request, wait for result.
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int CH_W     = 3,
  parameter int GRP_W    = 2,
  parameter int CNT_W    = 3,
  parameter int SAMP_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             stop,
  input  logic [CNT_W-1:0] delay_len,
  input  logic [CH_W-1:0]  grp_first,
  input  logic [GRP_W-1:0] grp_last,
  input  logic             req_ready,
  input  logic             res_valid,
  output logic             sh_en,
  output logic [CH_W-1:0]  sh_ch,
  output logic             req_valid,
  output logic [CH_W-1:0]  req_ch,
  output logic             store_en,
  output logic [CH_W-1:0]  store_ch,
  output logic             pass_done
);
  seq_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [GRP_W-1:0] idx;
  logic [CH_W-1:0]  first_q;
  logic [GRP_W-1:0] last_q;
  logic [CH_W-1:0]  cur_ch;
  logic             last_slot;

  assign cur_ch    = first_q + CH_W'(idx);
  assign last_slot = (idx == last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      first_q <= '0;
      last_q  <= '0;
    end else if (stop) begin
      st <= ST_IDLE;
    end else if (go) begin
      first_q <= grp_first;
      last_q  <= grp_last;
      idx     <= '0;
      cnt     <= delay_len;
      st      <= ST_DELAY;
    end else begin
      unique case (st)
        ST_DELAY: begin
          if (cnt == CNT_W'(1)) begin
            st  <= ST_SAMPLE;
            cnt <= CNT_W'(SAMP_CYC);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_SAMPLE: begin
          if (cnt == CNT_W'(1)) st <= ST_REQ;
          else                  cnt <= cnt - 1'b1;
        end
        ST_REQ: begin
          if (req_ready) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (res_valid) begin
            st  <= ST_SAMPLE;
            cnt <= CNT_W'(SAMP_CYC);
            idx <= last_slot ? '0 : idx + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign sh_en     = (st == ST_SAMPLE);
  assign sh_ch     = cur_ch;
  assign req_valid = (st == ST_REQ);
  assign req_ch    = cur_ch;
  assign store_en  = (st == ST_WAIT) && res_valid && !stop;
  assign store_ch  = cur_ch;
  assign pass_done = store_en && last_slot;

endmodule

// File: rtl/adc_scan_seq.sv
// Top: control bits, completion flag, interrupt, sequencer and result bank.
module adc_scan_seq #(
  parameter int NUM_CH   = 8,
  parameter int RES_W    = 10,
  parameter int PRE_DIV  = 4,
  parameter int SAMP_CYC = 3,
  parameter int MAX_GRP  = 4,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int GRP_W   = $clog2(MAX_GRP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_start,
  input  logic             cfg_irq_en,
  input  logic [CH_W-1:0]  cfg_first,
  input  logic [GRP_W-1:0] cfg_cnt,
  input  logic             flag_clr,
  input  logic [CH_W-1:0]  rd_sel,
  output logic [RES_W-1:0] rd_data,
  output logic             done_flag,
  output logic             irq,
  output logic             sh_en,
  output logic [CH_W-1:0]  sh_ch,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [CH_W-1:0]  req_ch,
  input  logic             res_valid,
  output logic             res_ready,
  input  logic [RES_W-1:0] res_data
);
  localparam int CNT_MAX = (PRE_DIV > SAMP_CYC) ? PRE_DIV : SAMP_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             start_q;
  logic             ie_q;
  logic             flag_q;
  logic             rdy_q;
  logic             go;
  logic             stop;
  logic [CNT_W-1:0] delay_len;
  logic             store_en;
  logic [CH_W-1:0]  store_ch;
  logic             pass_done;

  assign stop = cfg_we && !cfg_start;
  assign go   = cfg_we && cfg_start && !start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      if (cfg_we) begin
        start_q <= cfg_start;
        ie_q    <= cfg_irq_en;
      end
      if (pass_done)     flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assign done_flag = flag_q;
  assign irq       = flag_q && ie_q;
  assign res_ready = rdy_q;

  adc_scan_delay #(
    .PRE_DIV (PRE_DIV),
    .CNT_W   (CNT_W)
  ) u_delay (
    .clk       (clk),
    .rst_n     (rst_n),
    .delay_len (delay_len)
  );

  adc_scan_fsm #(
    .CH_W     (CH_W),
    .GRP_W    (GRP_W),
    .CNT_W    (CNT_W),
    .SAMP_CYC (SAMP_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .stop      (stop),
    .delay_len (delay_len),
    .grp_first (cfg_first),
    .grp_last  (cfg_cnt),
    .req_ready (req_ready),
    .res_valid (res_valid),
    .sh_en     (sh_en),
    .sh_ch     (sh_ch),
    .req_valid (req_valid),
    .req_ch    (req_ch),
    .store_en  (store_en),
    .store_ch  (store_ch),
    .pass_done (pass_done)
  );

  adc_scan_resbank #(
    .NUM_CH (NUM_CH),
    .RES_W  (RES_W),
    .CH_W   (CH_W)
  ) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (store_en),
    .waddr (store_ch),
    .wdata (res_data),
    .raddr (rd_sel),
    .rdata (rd_data)
  );

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int PRE_DIV = 4,
  parameter int CH_W    = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic            cfg_start,
  input logic            flag_clr,
  input logic            sh_en,
  input logic            req_valid,
  input logic            req_ready,
  input logic [CH_W-1:0] req_ch,
  input logic            done_flag,
  input logic            irq,
  input logic            pass_done
);
  logic       running;
  logic       waiting;
  logic [7:0] wcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      waiting <= 1'b0;
      wcnt    <= '0;
    end else if (cfg_we && !cfg_start) begin
      running <= 1'b0;
      waiting <= 1'b0;
    end else if (cfg_we && cfg_start && !running) begin
      running <= 1'b1;
      waiting <= 1'b1;
      wcnt    <= '0;
    end else if (waiting) begin
      if (sh_en) waiting <= 1'b0;
      else       wcnt <= wcnt + 1'b1;
    end
  end

  // R2
  start_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (wcnt <= 8'(PRE_DIV)));

  // R3
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sh_en, req_valid}));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !(cfg_we && !cfg_start)) |=> (req_valid && $stable(req_ch)));

  // R9
  idle_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!sh_en && !req_valid));

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |=> done_flag);

  // R6
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !pass_done) |=> !done_flag);

  // R7
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_flag);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(
  .PRE_DIV (PRE_DIV),
  .CH_W    (CH_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_start (cfg_start),
  .flag_clr  (flag_clr),
  .sh_en     (sh_en),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_ch    (req_ch),
  .done_flag (done_flag),
  .irq       (irq),
  .pass_done (pass_done)
);

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;
  localparam int NUM_CH = 8, RES_W = 10, PRE_DIV = 4, SAMP_CYC = 3, LAT = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_start = 0, cfg_irq_en = 0, flag_clr = 0, req_ready = 1;
  logic [2:0] cfg_first = 0, rd_sel = 0;
  logic [1:0] cfg_cnt = 0;
  logic [RES_W-1:0] rd_data, res_data;
  logic done_flag, irq, sh_en, req_valid, res_ready, res_valid;
  logic [2:0] sh_ch, req_ch;

  adc_scan_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_start(cfg_start),
    .cfg_irq_en(cfg_irq_en), .cfg_first(cfg_first), .cfg_cnt(cfg_cnt),
    .flag_clr(flag_clr), .rd_sel(rd_sel), .rd_data(rd_data),
    .done_flag(done_flag), .irq(irq), .sh_en(sh_en), .sh_ch(sh_ch),
    .req_valid(req_valid), .req_ready(req_ready), .req_ch(req_ch),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  int checks = 0, errors = 0;
  bit cmp_on = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model (phase: 0 idle, 1 delay, 2 sample, 3 request, 4 wait) and converter stub
  int kcyc, pre, m_phase, m_cnt, m_idx, m_first, m_last, m_ie, m_flag, m_run, seq, lat;
  int m_data [NUM_CH];
  bit done;

  always @(posedge clk) begin
    if (!rst_n) begin
      kcyc = 0; m_phase = 0; m_cnt = 0; m_idx = 0; m_first = 0; m_last = 0;
      m_ie = 0; m_flag = 0; m_run = 0; seq = 0;
      foreach (m_data[i]) m_data[i] = 0;
      res_valid <= 1'b0; res_data <= '0; lat <= 0;
    end else begin
      pre = kcyc % PRE_DIV;
      kcyc++;
      done = 0;
      if (cfg_we) m_ie = cfg_irq_en;
      if (cfg_we && !cfg_start) begin
        m_run = 0; m_phase = 0;
      end else if (cfg_we && cfg_start && m_run == 0) begin
        m_run = 1; m_first = cfg_first; m_last = cfg_cnt; m_idx = 0;
        m_phase = 1; m_cnt = PRE_DIV - pre;
      end else begin
        case (m_phase)
          1: if (m_cnt == 1) begin m_phase = 2; m_cnt = SAMP_CYC; end else m_cnt--;
          2: if (m_cnt == 1) m_phase = 3; else m_cnt--;
          3: if (req_ready) m_phase = 4;
          4: if (res_valid) begin
               m_data[(m_first + m_idx) % NUM_CH] = res_data;
               if (m_idx == m_last) begin done = 1; m_idx = 0; end else m_idx++;
               m_phase = 2; m_cnt = SAMP_CYC;
             end
          default: ;
        endcase
      end
      if (done) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      // converter stub: fixed latency after each accepted request
      if (res_valid && res_ready) res_valid <= 1'b0;
      if (lat > 0) lat <= lat - 1;
      if (lat == 1) begin
        res_valid <= 1'b1;
        res_data  <= RES_W'((seq * 11 + kcyc * 37) % 1024);
        seq++;
      end
      if (req_valid && req_ready) lat <= LAT;
    end
  end

  function automatic int exp_ch();
    return (m_first + m_idx) % NUM_CH;
  endfunction

  // Every-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && cmp_on) begin
      chk(sh_en == (m_phase == 2), "R2 R3 sh_en", sh_en, m_phase == 2);
      if (m_phase == 2) chk(sh_ch == exp_ch(), "R3 sh_ch", sh_ch, exp_ch());
      chk(req_valid == (m_phase == 3), "R4 req_valid", req_valid, m_phase == 3);
      if (m_phase == 3) chk(req_ch == exp_ch(), "R4 req_ch", req_ch, exp_ch());
      chk(done_flag == m_flag, "R6 done_flag", done_flag, m_flag);
      chk(irq == (m_flag && m_ie), "R7 irq", irq, m_flag && m_ie);
      chk(rd_data == m_data[rd_sel], "R5 R8 rd_data", rd_data, m_data[rd_sel]);
      chk(res_ready == 1'b1, "R5 res_ready", res_ready, 1);
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    forever begin
      @(negedge clk);
      rd_sel = rd_sel + 1'b1;
    end
  end

  task automatic cfg_write(input bit s, input bit ie, input logic [2:0] f, input logic [1:0] n);
    @(negedge clk);
    cfg_we = 1; cfg_start = s; cfg_irq_en = ie; cfg_first = f; cfg_cnt = n;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic wait_sh_rise(output int ch);
    bit prev;
    prev = sh_en;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #1;
      if (sh_en && !prev) break;
      prev = sh_en;
    end
    ch = sh_ch;
  endtask

  initial begin
    int ch, n;
    int wrap_exp [4] = '{6, 7, 0, 1};
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!sh_en && !req_valid, "R1 idle in reset", sh_en | req_valid, 0);
    chk(!done_flag && !irq, "R1 flag/irq in reset", done_flag | irq, 0);
    chk(res_ready == 0, "R1 res_ready in reset", res_ready, 0);
    chk(rd_data == 0, "R1 result reg in reset", rd_data, 0);
    rst_n = 1;
    cmp_on = 1;
    @(posedge clk); #1;
    chk(!sh_en && !done_flag, "R1 after reset", sh_en | done_flag, 0);

    // Main run: channels 2,3,4 with interrupt enabled
    cfg_write(1, 1, 3'd2, 2'd2);
    repeat (120) @(negedge clk);
    clear_flag();
    repeat (40) @(negedge clk);

    // R6: completion and clear in the same cycle
    clear_flag();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (m_phase == 4 && res_valid && m_idx == m_last) break;
    end
    flag_clr = 1;
    @(posedge clk); #1;
    chk(done_flag == 1, "R6 set beats clear", done_flag, 1);
    @(negedge clk); flag_clr = 0;

    // R10: start write while running leaves the group alone
    cfg_write(1, 1, 3'd5, 2'd0);
    wait_sh_rise(ch);
    chk(ch >= 2 && ch <= 4, "R10 group unchanged while running", ch, 2);
    wait_sh_rise(ch);
    chk(ch >= 2 && ch <= 4, "R10 group unchanged while running", ch, 3);

    // R4 back-pressure, then R9 stop with request pending
    @(negedge clk); req_ready = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (req_valid) break;
    end
    repeat (6) @(negedge clk);
    chk(req_valid == 1, "R4 request held under back-pressure", req_valid, 1);
    cfg_we = 1; cfg_start = 0;
    @(posedge clk); #1;
    chk(!req_valid && !sh_en, "R9 stop withdraws request", req_valid | sh_en, 0);
    @(negedge clk); cfg_we = 0; req_ready = 1;
    repeat (10) @(negedge clk);
    chk(!sh_en && !req_valid, "R9 stays idle", sh_en | req_valid, 0);

    // R9 restart at the first channel of a new group
    cfg_write(1, 1, 3'd5, 2'd0);
    wait_sh_rise(ch);
    chk(ch == 5, "R9 R10 restart at first channel", ch, 5);
    repeat (50) @(negedge clk);

    // R11 wrap-around, interrupt disabled (R7)
    cfg_write(0, 0, 3'd0, 2'd0);
    clear_flag();
    cfg_write(1, 0, 3'd6, 2'd3);
    for (int k = 0; k < 8; k++) begin
      wait_sh_rise(ch);
      chk(ch == wrap_exp[k % 4], "R11 R3 wrap order", ch, wrap_exp[k % 4]);
    end
    repeat (20) @(negedge clk);
    chk(done_flag == 1 && irq == 0, "R7 irq masked", irq, 0);

    // R2: start delay at varied prescaler phases
    for (int p = 0; p < 8; p++) begin
      cfg_write(0, 1, 3'd1, 2'd1);
      repeat (p) @(negedge clk);
      @(negedge clk);
      cfg_we = 1; cfg_start = 1; cfg_first = 3'd1; cfg_cnt = 2'd1;
      n = 0;
      for (int i = 0; i < 50; i++) begin
        @(posedge clk); #1;
        n++;
        cfg_we = 0;
        if (sh_en) break;
      end
      chk(n - 1 >= 1 && n - 1 <= PRE_DIV, "R2 start delay in range", n - 1, PRE_DIV);
      chk(sh_ch == 1, "R2 R9 first channel after start", sh_ch, 1);
      repeat (p * 3) @(negedge clk);
    end
    repeat (60) @(negedge clk);

    // R8: sweep all result registers explicitly
    for (int c = 0; c < NUM_CH; c++) begin
      @(negedge clk);
      #1;
      chk(rd_data == m_data[rd_sel], "R8 read port", rd_data, m_data[rd_sel]);
    end

    cfg_write(0, 0, 3'd0, 2'd0);
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end

endmodule